// File: doc/BRIEF.md
# Serial Bus Hold Pause Controller

This block sits beside the shift logic of a serial slave and decides when that logic pauses. It watches an active-low hold request, the serial clock and the active-low chip select, all asynchronous to the system clock. It brings the three inputs into the system clock domain together through one shared synchronizer, so their relative order is kept. From them it produces a pause flag, a high-impedance control for the serial data output, and a one-cycle request to reset the slave's logic.

The block starts and ends a pause only while the synchronized serial clock is low. A hold request that changes while the clock is high takes effect on the next low phase. While a pause is in force, the block masks the serial clock edge strobes that it passes to the slave. The slave's bit count and command state therefore freeze, and shifting resumes where it stopped. If chip select is released during a pause, the block asks for a reset of the slave logic. It then stays locked out until hold has been released and chip select has been taken low again, in that order.

Top module: `hold_pause_ctrl`

## Requirements
- R1: After reset, hold_active_o and logic_rst_o are 0, force_hiz_o is 1, and no clock strobe is produced.
- R2: With chip select low and the serial clock low, driving hold low sets hold_active_o within SYNC_STAGES+2 system clock cycles.
- R3: If hold goes low while the serial clock is high, hold_active_o stays 0 until the serial clock goes low, and is then set.
- R4: While paused, taking hold high with the serial clock low clears hold_active_o. Taking it high with the serial clock high keeps the pause until the serial clock goes low.
- R5: While hold_active_o is 1, force_hiz_o is 1, and serial clock edges produce no sck_rise_o or sck_fall_o strobe.
- R6: While selected and not paused, each rising serial clock edge gives exactly one sck_rise_o pulse and each falling edge gives exactly one sck_fall_o pulse, each one system clock cycle wide.
- R7: A low hold input while chip select is high never sets hold_active_o.
- R8: Chip select going high during a pause produces exactly one one-cycle logic_rst_o pulse and clears hold_active_o.
- R9: After such a reset, no pause, no strobe and force_hiz_o = 1 hold until hold is seen high with chip select high and chip select then goes low. A low hold in between restarts that wait.
- R10: force_hiz_o is 0 only while chip select is low and the block is neither paused nor locked out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_ni | input | 1 | Asynchronous active-low hold request |
| sck_i | input | 1 | Asynchronous serial clock |
| cs_ni | input | 1 | Asynchronous active-low chip select |
| hold_active_o | output | 1 | Pause in force; slave state frozen |
| force_hiz_o | output | 1 | Serial data output must be high impedance |
| logic_rst_o | output | 1 | One-cycle reset request for the slave logic |
| sck_rise_o | output | 1 | Qualified rising serial clock strobe |
| sck_fall_o | output | 1 | Qualified falling serial clock strobe |

## Verification
The bench drives hold against a clock that is held high, to catch a design that pauses at once instead of on the next low phase. It releases hold with the clock high for the same reason, since a wrong design would end the pause early. It toggles the serial clock during a pause and counts strobes. A design that leaked an edge would shift the slave's bit position. It then walks the lockout after a deselect in every order of hold and chip select, including hold dropping again mid-wait. A design without the lockout would re-pause or drive data after the reset.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RUN       = 3'd1,
    ST_PAUSE     = 3'd2,
    ST_LOCK_HOLD = 3'd3,
    ST_LOCK_CS   = 3'd4
  } hold_state_e;

  localparam int unsigned SIG_W   = 3;
  localparam int unsigned IDX_SCK  = 0;
  localparam int unsigned IDX_HOLD = 1;
  localparam int unsigned IDX_CS   = 2;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int unsigned  W       = 3,
  parameter int unsigned  STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sck_edge.sv
module sck_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b0;
    else         sck_prev_q <= sck_s_i;
  end

  assign rise_o = sck_s_i & ~sck_prev_q;
  assign fall_o = ~sck_s_i & sck_prev_q;
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic hold_ns_i,
  input  logic cs_ns_i,
  output logic run_o,
  output logic paused_o,
  output logic logic_rst_o
);
  hold_state_e state_q, state_d;
  logic        rst_req_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (!cs_ns_i) state_d = ST_RUN;
      ST_RUN: begin
        if (cs_ns_i)                    state_d = ST_IDLE;
        else if (!hold_ns_i && !sck_s_i) state_d = ST_PAUSE;
      end
      ST_PAUSE: begin
        if (cs_ns_i)                    state_d = ST_LOCK_HOLD;
        else if (hold_ns_i && !sck_s_i) state_d = ST_RUN;
      end
      ST_LOCK_HOLD: if (hold_ns_i && cs_ns_i) state_d = ST_LOCK_CS;
      ST_LOCK_CS: begin
        if (!hold_ns_i)    state_d = ST_LOCK_HOLD;
        else if (!cs_ns_i) state_d = ST_RUN;
      end
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rst_req_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rst_req_q <= (state_q == ST_PAUSE) && cs_ns_i;
    end
  end

  assign run_o       = (state_q == ST_RUN);
  assign paused_o    = (state_q == ST_PAUSE);
  assign logic_rst_o = rst_req_q;

  // R2/R3: a pause begins only from a selected, low-clock, hold-low cycle
  p_entry_clk_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused_o) |-> $past(!sck_s_i && !hold_ns_i && !cs_ns_i));

  // R4: a pause ends on deselect or on hold release with the clock low
  p_exit_clk_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(paused_o) |-> $past(cs_ns_i || (hold_ns_i && !sck_s_i)));

  // R8: reset request only follows a deselect during a pause
  p_rst_from_pause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_rst_o |-> $past(paused_o && cs_ns_i));

  // R8: the reset request lasts one cycle
  p_rst_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_rst_o |=> !logic_rst_o);

  // R9: after a reset request neither run nor pause follows directly
  p_lockout_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_rst_o |-> !paused_o && !run_o);
endmodule

// File: rtl/hold_pause_ctrl.sv
module hold_pause_ctrl
  import hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_ni,
  input  logic sck_i,
  input  logic cs_ni,
  output logic hold_active_o,
  output logic force_hiz_o,
  output logic logic_rst_o,
  output logic sck_rise_o,
  output logic sck_fall_o
);
  localparam logic [SIG_W-1:0] SYNC_RST = (SIG_W'(1) << IDX_HOLD) | (SIG_W'(1) << IDX_CS);

  logic [SIG_W-1:0] raw, synced;
  logic             rise, fall, run, paused;

  assign raw[IDX_SCK]  = sck_i;
  assign raw[IDX_HOLD] = hold_ni;
  assign raw[IDX_CS]   = cs_ni;

  // one bank for all three inputs keeps their relative order
  sync_bank #(.W(SIG_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(synced)
  );

  sck_edge u_edge (
    .clk_i, .rst_ni, .sck_s_i(synced[IDX_SCK]), .rise_o(rise), .fall_o(fall)
  );

  hold_fsm u_fsm (
    .clk_i, .rst_ni,
    .sck_s_i(synced[IDX_SCK]), .hold_ns_i(synced[IDX_HOLD]), .cs_ns_i(synced[IDX_CS]),
    .run_o(run), .paused_o(paused), .logic_rst_o(logic_rst_o)
  );

  wire live = run & ~synced[IDX_CS];

  assign hold_active_o = paused;
  assign force_hiz_o   = ~live;
  assign sck_rise_o    = rise & live;
  assign sck_fall_o    = fall & live;

  // R5: no strobe and no drive during a pause
  p_pause_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_active_o |-> force_hiz_o && !sck_rise_o && !sck_fall_o);

  // R10: output driven only while chip select is low
  p_drive_selected_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_hiz_o |-> !synced[IDX_CS]);

  // R6: strobes are single-cycle
  p_strobe_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise_o |=> !sck_rise_o);
endmodule

// File: tb/tb_hold_pause_ctrl.sv
`timescale 1ns/1ps
module tb_hold_pause_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hold_ni = 1'b1, sck_i = 1'b0, cs_ni = 1'b1;
  logic hold_active_o, force_hiz_o, logic_rst_o, sck_rise_o, sck_fall_o;

  int n_tests = 0, n_fail = 0;
  int rise_cnt = 0, fall_cnt = 0, rst_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hold_pause_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .hold_ni(hold_ni), .sck_i(sck_i), .cs_ni(cs_ni),
    .hold_active_o(hold_active_o), .force_hiz_o(force_hiz_o), .logic_rst_o(logic_rst_o),
    .sck_rise_o(sck_rise_o), .sck_fall_o(sck_fall_o)
  );

  always @(negedge clk) begin
    if (sck_rise_o)  rise_cnt++;
    if (sck_fall_o)  fall_cnt++;
    if (logic_rst_o) rst_cnt++;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_sck(int n);
    for (int i = 0; i < n; i++) begin
      sck_i = 1'b1; wait_cyc(6);
      sck_i = 1'b0; wait_cyc(6);
    end
  endtask

  task automatic t_reset_r1;
    wait_cyc(3);
    chk("R1 hold_active", hold_active_o, 0);
    chk("R1 force_hiz", force_hiz_o, 1);
    chk("R1 logic_rst", logic_rst_o, 0);
    chk("R1 strobes", rise_cnt + fall_cnt, 0);
  endtask

  task automatic t_cs_high_hold_r7;
    hold_ni = 1'b0; wait_cyc(10);
    chk("R7 no pause while deselected", hold_active_o, 0);
    chk("R10 hiz while deselected", force_hiz_o, 1);
    hold_ni = 1'b1; wait_cyc(6);
  endtask

  task automatic t_run_strobes_r6;
    int r0, f0;
    cs_ni = 1'b0; wait_cyc(6);
    chk("R10 driven when selected", force_hiz_o, 0);
    r0 = rise_cnt; f0 = fall_cnt;
    pulse_sck(5);
    chk("R6 rise count", rise_cnt - r0, 5);
    chk("R6 fall count", fall_cnt - f0, 5);
  endtask

  task automatic t_entry_low_r2;
    hold_ni = 1'b0; wait_cyc(4);
    chk("R2 pause within latency", hold_active_o, 1);
    chk("R5 hiz in pause", force_hiz_o, 1);
  endtask

  task automatic t_pause_masks_r5;
    int r0, f0;
    r0 = rise_cnt; f0 = fall_cnt;
    pulse_sck(4);
    chk("R5 no rise in pause", rise_cnt - r0, 0);
    chk("R5 no fall in pause", fall_cnt - f0, 0);
    chk("R5 still paused", hold_active_o, 1);
  endtask

  task automatic t_exit_low_r4;
    int r0;
    hold_ni = 1'b1; wait_cyc(4);
    chk("R4 exit with clock low", hold_active_o, 0);
    chk("R10 driven after exit", force_hiz_o, 0);
    r0 = rise_cnt;
    pulse_sck(2);
    chk("R6 strobes resume", rise_cnt - r0, 2);
  endtask

  task automatic t_deferred_r3_r4;
    sck_i = 1'b1; wait_cyc(6);
    hold_ni = 1'b0; wait_cyc(10);
    chk("R3 entry deferred while clock high", hold_active_o, 0);
    sck_i = 1'b0; wait_cyc(4);
    chk("R3 entry on clock low", hold_active_o, 1);
    sck_i = 1'b1; wait_cyc(6);
    hold_ni = 1'b1; wait_cyc(10);
    chk("R4 exit deferred while clock high", hold_active_o, 1);
    sck_i = 1'b0; wait_cyc(4);
    chk("R4 exit on clock low", hold_active_o, 0);
  endtask

  task automatic t_deselect_r8_r9;
    int r0, k0;
    hold_ni = 1'b0; wait_cyc(6);
    chk("R8 paused before deselect", hold_active_o, 1);
    k0 = rst_cnt;
    cs_ni = 1'b1; wait_cyc(8);
    chk("R8 one reset pulse", rst_cnt - k0, 1);
    chk("R8 pause cleared", hold_active_o, 0);
    // reselect with hold still low: locked
    cs_ni = 1'b0; wait_cyc(8);
    chk("R9 no re-pause", hold_active_o, 0);
    chk("R9 hiz in lockout", force_hiz_o, 1);
    r0 = rise_cnt;
    pulse_sck(2);
    chk("R9 no strobes in lockout", rise_cnt - r0, 0);
    // hold high while selected is not enough
    hold_ni = 1'b1; wait_cyc(8);
    chk("R9 still locked, cs not cycled", force_hiz_o, 1);
    // hold high with cs high, then hold low again: wait restarts
    cs_ni = 1'b1; wait_cyc(8);
    hold_ni = 1'b0; wait_cyc(8);
    cs_ni = 1'b0; wait_cyc(8);
    chk("R9 hold drop restarts wait", force_hiz_o, 1);
    chk("R9 no pause after restart", hold_active_o, 0);
    // proper order: hold high with cs high, then cs low
    cs_ni = 1'b1; wait_cyc(6);
    hold_ni = 1'b1; wait_cyc(6);
    cs_ni = 1'b0; wait_cyc(6);
    chk("R9 released after hold then cs", force_hiz_o, 0);
    r0 = rise_cnt;
    pulse_sck(3);
    chk("R9 strobes after release", rise_cnt - r0, 3);
    chk("R8 no further reset", rst_cnt - k0, 1);
  endtask

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    t_reset_r1();
    t_cs_high_hold_r7();
    t_run_strobes_r6();
    t_entry_low_r2();
    t_pause_masks_r5();
    t_exit_low_r4();
    t_deferred_r3_r4();
    t_deselect_r8_r9();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule